// File: doc/BRIEF.md
# Outstanding Miss Tracking Table

This block records the line fetches that a cache has sent to the next memory level and not yet seen returned. Its storage is fully associative, so any slot can hold any block address. A slot holds a block address and the identifiers of the requests waiting on that block. The identifiers are kept in the order they arrived. A slot accepts at most `MAX_MERGE` identifiers, and the table holds at most `N_ENT` slots.

The cache controller uses the table in four ways:

- It looks up a block address to learn whether a fetch for that block is already outstanding, and whether one more request can still be recorded.
- It records a request identifier. The identifier is merged into the existing slot for that block, or it opens a new slot.
- When a fill comes back, it reports the block as returned. The slot then joins a ready queue.
- It drains the ready queue, one identifier per cycle. A slot is released only after its last waiting identifier has been taken.

The table always accepts fill notices. An illegal operation sets a sticky error flag and changes nothing else.

Top module: `pend_miss_table`

## Requirements
- R1: `req_hit` is combinationally high exactly when a live slot holds the block address on `req_addr`. No two live slots ever hold the same address.
- R2: `req_full` is evaluated on the state before the clock edge. For an address with a live slot, it is high when that slot holds `MAX_MERGE` identifiers. For an address with no slot, it is high when all `N_ENT` slots are live.
- R3: An add (`add_en` high, `req_full` low) for an address with no slot opens a new slot in the lowest free position. From the next cycle, `req_hit` is high for that address.
- R4: An add for an address with a live slot appends `add_id` to that slot. The identifiers of one slot leave through `pop_id` in the order they were added.
- R5: Marking a block returned (`mark_en`, `mark_addr`) places its slot at the tail of the ready queue. Slots are drained in the order they were marked. `pop_valid` is high exactly while the queue is non-empty, and `pop_id` shows the oldest identifier of the slot at the head.
- R6: When the last identifier of a slot is popped, the slot is freed. From the next cycle, `req_hit` is low for its address, and the position can be opened again.
- R7: While `pop_valid` and `pop_take` are both high at a clock edge, exactly one identifier is removed on that edge.
- R8: `fill_busy` is always low, so a fill notice is never refused.
- R9: `err` becomes 1 and stays 1 until reset in any of these cases:
  - an add while `req_full` is high;
  - a mark for an address with no live slot;
  - a mark for a slot that is already in the ready queue.

  The offending operation has no other effect.
- R10: The ready queue never holds more slots than there are live slots.
- R11: After reset, no slot is live, `pop_valid` is 0 and `err` is 0.
- R12: An add to a slot in the same cycle that its single remaining identifier is popped keeps the slot live and queued. The new identifier is then at its head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | ADDR_W | Block address for lookup and add |
| req_hit | output | 1 | A slot is live for `req_addr` |
| req_full | output | 1 | An add for `req_addr` would be refused |
| add_en | input | 1 | Record `add_id` against `req_addr` |
| add_id | input | ID_W | Request identifier to record |
| mark_en | input | 1 | Fill has returned for `mark_addr` |
| mark_addr | input | ADDR_W | Block address of the returned fill |
| fill_busy | output | 1 | Fill notices refused (always 0) |
| pop_valid | output | 1 | A returned identifier is available |
| pop_id | output | ID_W | Oldest identifier of the head ready slot |
| pop_take | input | 1 | Remove `pop_id` on this edge |
| err | output | 1 | Sticky illegal-operation flag |

## Verification
The checker watches a set of invariants on every cycle:

- address uniqueness across live slots;
- the bound of the ready queue against the live slot count;
- growth of at most one slot per cycle;
- stickiness of the error flag;
- the error following every add while full and every illegal mark.

Only the bench scenarios can show the ordering properties. These are the arrival order of identifiers inside one slot, the order in which marked slots drain, the freeing and reuse of slots, and the add that meets the final pop in the same cycle. Each of these needs a known sequence of identifiers to compare against.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  // a slot refuses another identifier once it holds the merge limit
  function automatic logic slot_at_limit(input int held, input int limit);
    return held >= limit;
  endfunction

  // a table refuses a new block once every slot is live
  function automatic logic table_at_limit(input int live, input int slots);
    return live >= slots;
  endfunction

endpackage

// File: rtl/pmt_entry.sv
module pmt_entry #(
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 6,
  parameter int MAX_MERGE = 3,
  parameter int MCNT_W    = $clog2(MAX_MERGE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              append,
  input  logic              pop,
  input  logic              mark,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ID_W-1:0]   in_id,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [MCNT_W-1:0] cnt,
  output logic [ID_W-1:0]   head,
  output logic              rdy
);
  localparam int LIST_W = MAX_MERGE * ID_W;

  logic [LIST_W-1:0] ids, ids_nxt, base;
  logic [MCNT_W-1:0] wpos;
  logic              last_out;

  assign head     = ids[ID_W-1:0];
  assign last_out = pop && !append && (cnt == MCNT_W'(1));

  always_comb begin
    base = pop ? (ids >> ID_W) : ids;
    wpos = pop ? (cnt - MCNT_W'(1)) : cnt;
    ids_nxt = base;
    for (int k = 0; k < MAX_MERGE; k++) begin
      if (append && (MCNT_W'(k) == wpos))
        ids_nxt[k*ID_W +: ID_W] = in_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      rdy   <= 1'b0;
      cnt   <= '0;
      addr  <= '0;
      ids   <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      rdy   <= 1'b0;
      addr  <= in_addr;
      cnt   <= MCNT_W'(1);
      ids   <= {{(LIST_W-ID_W){1'b0}}, in_id};
    end else begin
      ids <= ids_nxt;
      if (mark) rdy <= 1'b1;
      if (pop && !append) cnt <= cnt - MCNT_W'(1);
      else if (append && !pop) cnt <= cnt + MCNT_W'(1);
      if (last_out) begin
        valid <= 1'b0;
        rdy   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pmt_ready_q.sv
module pmt_ready_q #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int QCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic              pop,
  output logic [IDX_W-1:0]  head,
  output logic              empty,
  output logic [QCNT_W-1:0] count
);
  logic [IDX_W-1:0] slots [DEPTH];
  logic [IDX_W-1:0] rd_p, wr_p;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + IDX_W'(1);
  endfunction

  assign head  = slots[rd_p];
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p  <= '0;
      wr_p  <= '0;
      count <= '0;
      for (int k = 0; k < DEPTH; k++) slots[k] <= '0;
    end else begin
      if (push) begin
        slots[wr_p] <= push_idx;
        wr_p        <= step(wr_p);
      end
      if (pop) rd_p <= step(rd_p);
      if (push && !pop) count <= count + QCNT_W'(1);
      else if (pop && !push) count <= count - QCNT_W'(1);
    end
  end
endmodule

// File: rtl/pend_miss_table.sv
module pend_miss_table #(
  parameter int N_ENT     = 4,
  parameter int MAX_MERGE = 3,
  parameter int ADDR_W    = 16,
  parameter int ID_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_hit,
  output logic              req_full,
  input  logic              add_en,
  input  logic [ID_W-1:0]   add_id,
  input  logic              mark_en,
  input  logic [ADDR_W-1:0] mark_addr,
  output logic              fill_busy,
  output logic              pop_valid,
  output logic [ID_W-1:0]   pop_id,
  input  logic              pop_take,
  output logic              err
);
  import pmt_pkg::*;

  localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int MCNT_W = $clog2(MAX_MERGE + 1);
  localparam int QCNT_W = $clog2(N_ENT + 1);

  logic [N_ENT-1:0]  ent_valid, ent_rdy, req_match, mark_match;
  logic [ADDR_W-1:0] ent_addr [N_ENT];
  logic [MCNT_W-1:0] ent_cnt  [N_ENT];
  logic [ID_W-1:0]   ent_head [N_ENT];

  logic [IDX_W-1:0]  hit_idx, free_idx, mark_idx, q_head;
  logic [QCNT_W-1:0] live_cnt, q_count;
  logic              q_empty, mark_hit, mark_dup;
  logic              add_ok, add_new, add_merge, mark_ok, pop_fire, head_release;

  function automatic logic [IDX_W-1:0] first_one(input logic [N_ENT-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = N_ENT - 1; k >= 0; k--)
      if (v[k]) r = IDX_W'(k);
    return r;
  endfunction

  function automatic logic [QCNT_W-1:0] ones(input logic [N_ENT-1:0] v);
    logic [QCNT_W-1:0] r;
    r = '0;
    for (int k = 0; k < N_ENT; k++)
      r = r + QCNT_W'(v[k]);
    return r;
  endfunction

  // lookup side
  always_comb begin
    for (int k = 0; k < N_ENT; k++) begin
      req_match[k]  = ent_valid[k] && (ent_addr[k] == req_addr);
      mark_match[k] = ent_valid[k] && (ent_addr[k] == mark_addr);
    end
  end

  assign req_hit  = |req_match;
  assign hit_idx  = first_one(req_match);
  assign free_idx = first_one(~ent_valid);
  assign live_cnt = ones(ent_valid);
  assign req_full = req_hit ? slot_at_limit(int'(ent_cnt[hit_idx]), MAX_MERGE)
                            : table_at_limit(int'(live_cnt), N_ENT);

  assign add_ok    = add_en && !req_full;
  assign add_new   = add_ok && !req_hit;
  assign add_merge = add_ok && req_hit;

  assign mark_hit = |mark_match;
  assign mark_idx = first_one(mark_match);
  assign mark_dup = mark_hit && ent_rdy[mark_idx];
  assign mark_ok  = mark_en && mark_hit && !mark_dup;

  // drain side
  assign fill_busy    = 1'b0;
  assign pop_valid    = !q_empty;
  assign pop_id       = ent_head[q_head];
  assign pop_fire     = pop_valid && pop_take;
  assign head_release = pop_fire && (ent_cnt[q_head] == MCNT_W'(1))
                        && !(add_merge && (hit_idx == q_head));

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    pmt_entry #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .MAX_MERGE(MAX_MERGE), .MCNT_W(MCNT_W)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .alloc  (add_new && (free_idx == IDX_W'(g))),
      .append (add_merge && (hit_idx == IDX_W'(g))),
      .pop    (pop_fire && (q_head == IDX_W'(g))),
      .mark   (mark_ok && (mark_idx == IDX_W'(g))),
      .in_addr(req_addr),
      .in_id  (add_id),
      .valid  (ent_valid[g]),
      .addr   (ent_addr[g]),
      .cnt    (ent_cnt[g]),
      .head   (ent_head[g]),
      .rdy    (ent_rdy[g])
    );
  end

  pmt_ready_q #(.DEPTH(N_ENT), .IDX_W(IDX_W), .QCNT_W(QCNT_W)) u_rq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (mark_ok),
    .push_idx(mark_idx),
    .pop     (head_release),
    .head    (q_head),
    .empty   (q_empty),
    .count   (q_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else if ((add_en && req_full) || (mark_en && !mark_ok)) err <= 1'b1;
  end
endmodule

// File: rtl/pmt_chk.sv
module pmt_chk #(
  parameter int N_ENT  = 4,
  parameter int QCNT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              err,
  input logic              add_en,
  input logic              req_full,
  input logic              mark_en,
  input logic              mark_ok,
  input logic [N_ENT-1:0]  ent_valid,
  input logic [N_ENT-1:0]  req_match,
  input logic [QCNT_W-1:0] q_count,
  input logic [QCNT_W-1:0] live_cnt
);
  assert_unique_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_match));

  assert_one_open_per_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ent_valid) <= $countones($past(ent_valid)) + 1);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_add_full_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && req_full) |=> err);

  assert_bad_mark_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !mark_ok) |=> err);

  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= live_cnt);
endmodule

bind pend_miss_table pmt_chk #(.N_ENT(N_ENT), .QCNT_W(QCNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .err      (err),
  .add_en   (add_en),
  .req_full (req_full),
  .mark_en  (mark_en),
  .mark_ok  (mark_ok),
  .ent_valid(ent_valid),
  .req_match(req_match),
  .q_count  (q_count),
  .live_cnt (live_cnt)
);

// File: tb/pend_miss_table_test.sv
`timescale 1ns/1ps
module pend_miss_table_test;
  localparam int N_ENT = 4, MAX_MERGE = 3, ADDR_W = 16, ID_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0, mark_addr = '0;
  logic add_en = 1'b0, mark_en = 1'b0, pop_take = 1'b0;
  logic [ID_W-1:0] add_id = '0;
  logic req_hit, req_full, fill_busy, pop_valid, err;
  logic [ID_W-1:0] pop_id;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pend_miss_table #(.N_ENT(N_ENT), .MAX_MERGE(MAX_MERGE), .ADDR_W(ADDR_W), .ID_W(ID_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_hit(req_hit), .req_full(req_full),
    .add_en(add_en), .add_id(add_id), .mark_en(mark_en), .mark_addr(mark_addr),
    .fill_busy(fill_busy), .pop_valid(pop_valid), .pop_id(pop_id), .pop_take(pop_take),
    .err(err));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic do_add(int a, int id);
    @(negedge clk); req_addr = ADDR_W'(a); add_id = ID_W'(id); add_en = 1'b1;
    @(posedge clk); #1 add_en = 1'b0;
  endtask

  task automatic do_mark(int a);
    @(negedge clk); mark_addr = ADDR_W'(a); mark_en = 1'b1;
    @(posedge clk); #1 mark_en = 1'b0;
  endtask

  task automatic look(string req, int a, int hit, int full);
    @(negedge clk); req_addr = ADDR_W'(a); #1;
    chk({req, " hit"}, int'(req_hit), hit);
    chk({req, " full"}, int'(req_full), full);
  endtask

  task automatic do_pop(string req, int id);
    @(negedge clk); #1;
    chk({req, " pop_valid"}, int'(pop_valid), 1);
    chk({req, " pop_id"}, int'(pop_id), id);
    pop_take = 1'b1;
    @(posedge clk); #1 pop_take = 1'b0;
  endtask

  task automatic idle(string req);
    @(negedge clk); #1;
    chk({req, " queue empty"}, int'(pop_valid), 0);
  endtask

  task automatic t_reset();
    look("R11", 16'h0040, 0, 0);
    chk("R11 pop_valid", int'(pop_valid), 0);
    chk("R11 err", int'(err), 0);
    chk("R8 fill_busy", int'(fill_busy), 0);
  endtask

  task automatic t_merge();
    do_add(16'h0100, 1);
    look("R3 new slot", 16'h0100, 1, 0);
    do_add(16'h0100, 2);
    do_add(16'h0100, 3);
    look("R2 merge limit", 16'h0100, 1, 1);
    idle("R5 unmarked");
    do_mark(16'h0100);
    chk("R8 fill_busy", int'(fill_busy), 0);
    do_pop("R4 order", 1);
    do_pop("R4 order", 2);
    do_pop("R4 order", 3);
    look("R6 freed", 16'h0100, 0, 0);
    idle("R6 drained");
    chk("R9 no err", int'(err), 0);
  endtask

  task automatic t_table_full();
    for (int k = 0; k < N_ENT; k++) do_add(16'h0200 + k, 10 + k);
    look("R2 table full", 16'h0300, 0, 1);
    look("R2 slot room", 16'h0200, 1, 0);
    do_add(16'h0300, 20);
    look("R9 refused add", 16'h0300, 0, 1);
    chk("R9 err set", int'(err), 1);
    repeat (3) @(negedge clk);
    chk("R9 err sticky", int'(err), 1);
    do_reset();
    chk("R11 err cleared", int'(err), 0);
    look("R11 empty", 16'h0200, 0, 0);
  endtask

  task automatic t_ready_order();
    do_add(16'h0400, 30);
    do_add(16'h0500, 31);
    do_add(16'h0400, 32);
    do_add(16'h0600, 33);
    do_mark(16'h0600);
    do_mark(16'h0400);
    do_pop("R5 mark order", 33);
    // R7: hold pop_take for two edges, expect exactly two identifiers out
    @(negedge clk); #1;
    chk("R7 first", int'(pop_id), 30);
    pop_take = 1'b1;
    @(negedge clk); #1;
    chk("R7 second", int'(pop_id), 32);
    chk("R7 still valid", int'(pop_valid), 1);
    @(posedge clk); #1 pop_take = 1'b0;
    idle("R5 unmarked slot");
    look("R1 pending kept", 16'h0500, 1, 0);
    do_mark(16'h0500);
    do_pop("R5 late mark", 31);
    idle("R6 all drained");
    chk("R9 no err", int'(err), 0);
  endtask

  task automatic t_bad_mark();
    do_mark(16'h0700);
    chk("R9 unknown mark", int'(err), 1);
    idle("R9 unknown mark ignored");
    do_reset();
    do_add(16'h0800, 40);
    do_mark(16'h0800);
    do_mark(16'h0800);
    chk("R9 double mark", int'(err), 1);
    do_pop("R9 single queue item", 40);
    idle("R9 no duplicate in queue");
    do_reset();
  endtask

  task automatic t_meet();
    do_add(16'h0900, 50);
    do_mark(16'h0900);
    @(negedge clk); req_addr = 16'h0900; add_id = 6'd51; add_en = 1'b1; pop_take = 1'b1;
    #1 chk("R12 pop before", int'(pop_id), 50);
    @(posedge clk); #1 begin add_en = 1'b0; pop_take = 1'b0; end
    look("R12 kept", 16'h0900, 1, 0);
    do_pop("R12 new head", 51);
    look("R6 freed", 16'h0900, 0, 0);
    for (int k = 0; k < N_ENT; k++) do_add(16'h0A00 + k, k);
    look("R6 reuse", 16'h0A03, 1, 0);
    chk("R6 reuse no err", int'(err), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_merge();
    t_table_full();
    t_ready_order();
    t_bad_mark();
    t_meet();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule